// File: doc/BRIEF.md
# Leaky Edge Counter with Gray-Coded Crossing

The block counts rising edges of an asynchronous strobe and holds a running total in the system clock domain. The strobe may slow down and stop at any time. A small binary counter is clocked directly by the strobe. Its value is re-encoded in Gray code and carried into the system domain through a two-flop synchronizer. On the system side the value is decoded again, and the change since the previous system clock is added to an accumulator.

A free-running leak timer takes one from the accumulator at a fixed interval. A registered flag reports whenever the total is above a programmable threshold. Nothing ever travels back into the strobe domain, so a strobe that has stopped cannot hold up the leak or the flag.

The leak interval, the threshold and the accumulator width are parameters. The default leak interval is 62500 cycles, which is 500 µs at 125 MHz, and the default threshold is 25.

Top module: `leaky_edge_counter`

## Requirements
- R1: Every rising edge of `strobe_i` adds one to `level_o` after the synchronizer latency, once the strobe-side reset release has completed.
- R2: The system side takes the modulo-16 difference between successive decoded 4-bit counts. The total stays correct across counter wrap while the strobe runs up to 7 times faster than `clk_i`.
- R3: One is taken from `level_o` on every LEAK_CYCLES-th system clock edge after reset release, and at no other time.
- R4: `level_o` never goes below zero. A leak that lands on an empty accumulator with no new edges leaves it at 0, and any decrease is exactly one.
- R5: `level_o` saturates at 2^ACC_W-1 instead of wrapping. A leak and an increment in the same cycle apply the increment minus one.
- R6: `over_o` is 1 exactly in the cycles where `level_o` is greater than THRESHOLD.
- R7: While `rst_ni` is low, `level_o` is 0 and `over_o` is 0.
- R8: The first two rising edges of `strobe_i` after reset release are used to release the strobe-side reset and are not counted.
- R9: While the strobe is stopped, `level_o` changes only through leak ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| strobe_i | input | 1 | Asynchronous strobe whose rising edges are counted |
| level_o | output | ACC_W | Saturating leaky total |
| over_o | output | 1 | High while level_o exceeds THRESHOLD |

## Verification
The bench sweeps burst lengths from 0 to 20 edges twice, at two strobe rates. At the slow rate each system sample sees at most one new edge. At the fast rate each sample sees two edges, so the Gray decode and the modular subtraction are exercised across every wrap of the 4-bit counter.

Each burst is followed by a quiet stretch. The total is checked just after the first leak tick, then again between ticks to confirm it holds still, and then after enough ticks to drain it to zero. This separates a correct floor from underflow wrap. Burst lengths on both sides of the threshold show the flag switching at the right total.

A final long burst drives the total into the ceiling while leak ticks keep landing. This separates saturation from a wrapping accumulator.

// File: rtl/leaky_pkg.sv
package leaky_pkg;
  localparam int unsigned CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t bin2gray(cnt_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic cnt_t gray2bin(cnt_t g);
    cnt_t b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/leaky_strobe_side.sv
module leaky_strobe_side
  import leaky_pkg::*;
(
  input  logic strobe_i,
  input  logic rst_ni,
  output cnt_t gray_o
);
  logic [1:0] rel_q;
  logic       srst_n;
  cnt_t       bin_q, gray_q, bin_nx;

  // reset asserts at once, releases on the second strobe edge
  always_ff @(posedge strobe_i or negedge rst_ni) begin
    if (!rst_ni) rel_q <= '0;
    else         rel_q <= {rel_q[0], 1'b1};
  end
  assign srst_n = rel_q[1];
  assign bin_nx = bin_q + cnt_t'(1);

  always_ff @(posedge strobe_i or negedge srst_n) begin
    if (!srst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin2gray(bin_nx);
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/leaky_gray_sync.sv
module leaky_gray_sync
  import leaky_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t gray_i,
  output cnt_t bin_o
);
  cnt_t sync_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= gray_i;
      else            sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign bin_o = gray2bin(sync_q[STAGES-1]);
endmodule

// File: rtl/leaky_acc.sv
module leaky_acc
  import leaky_pkg::*;
#(
  parameter int unsigned ACC_W       = 8,
  parameter int unsigned LEAK_CYCLES = 62500,
  parameter int unsigned THRESHOLD   = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_t             cnt_i,
  output logic [ACC_W-1:0] level_o,
  output logic             over_o
);
  localparam int unsigned TMR_W = (LEAK_CYCLES > 1) ? $clog2(LEAK_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(LEAK_CYCLES - 1);
  localparam logic [ACC_W:0]   ACC_MAX  = {1'b0, {ACC_W{1'b1}}};
  localparam logic [ACC_W-1:0] THR      = ACC_W'(THRESHOLD);

  logic [TMR_W-1:0] tmr_q;
  logic             tick;
  cnt_t             prev_q, delta;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             flag_q;

  assign tick  = (tmr_q == TMR_LAST);
  assign delta = cnt_i - prev_q;  // modular

  always_comb begin
    sum = {1'b0, acc_q} + (ACC_W+1)'(delta);
    if (tick && sum != '0) sum = sum - (ACC_W+1)'(1);
    acc_d = (sum > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      prev_q <= '0;
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      tmr_q  <= tick ? '0 : tmr_q + TMR_W'(1);
      prev_q <= cnt_i;
      acc_q  <= acc_d;
      flag_q <= (acc_d > THR);
    end
  end

  assign level_o = acc_q;
  assign over_o  = flag_q;
endmodule

// File: rtl/leaky_edge_counter.sv
module leaky_edge_counter
  import leaky_pkg::*;
#(
  parameter int unsigned ACC_W       = 8,
  parameter int unsigned LEAK_CYCLES = 62500,
  parameter int unsigned THRESHOLD   = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  output logic [ACC_W-1:0] level_o,
  output logic             over_o
);
  cnt_t gray_s, bin_s;

  leaky_strobe_side u_strobe (
    .strobe_i(strobe_i),
    .rst_ni  (rst_ni),
    .gray_o  (gray_s)
  );

  leaky_gray_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gray_i(gray_s),
    .bin_o (bin_s)
  );

  leaky_acc #(
    .ACC_W      (ACC_W),
    .LEAK_CYCLES(LEAK_CYCLES),
    .THRESHOLD  (THRESHOLD)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (bin_s),
    .level_o(level_o),
    .over_o (over_o)
  );
endmodule

// File: rtl/leaky_edge_counter_chk.sv
module leaky_edge_counter_chk #(
  parameter int unsigned ACC_W       = 8,
  parameter int unsigned LEAK_CYCLES = 62500,
  parameter int unsigned THRESHOLD   = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ACC_W-1:0] level_o,
  input logic             over_o
);
  localparam int unsigned TMR_W = (LEAK_CYCLES > 1) ? $clog2(LEAK_CYCLES) : 1;
  localparam logic [ACC_W-1:0] LVL_MAX = {ACC_W{1'b1}};

  logic [TMR_W-1:0] t_q;
  logic             chk_tick;
  assign chk_tick = (t_q == TMR_W'(LEAK_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       t_q <= '0;
    else if (chk_tick) t_q <= '0;
    else               t_q <= t_q + TMR_W'(1);
  end

  // R3
  leak_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o < $past(level_o)) |-> $past(chk_tick));

  // R4
  leak_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o < $past(level_o)) |-> (level_o == $past(level_o) - ACC_W'(1)));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(level_o) == LVL_MAX) |-> (level_o >= LVL_MAX - ACC_W'(1)));

  // R6
  over_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o == (level_o > ACC_W'(THRESHOLD)));
endmodule

bind leaky_edge_counter leaky_edge_counter_chk #(
  .ACC_W(ACC_W), .LEAK_CYCLES(LEAK_CYCLES), .THRESHOLD(THRESHOLD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .level_o(level_o), .over_o(over_o)
);

// File: tb/leaky_edge_counter_tb.sv
`timescale 1ns/1ps
module leaky_edge_counter_tb;
  localparam int ACC_W = 5;
  localparam int LEAK  = 64;
  localparam int THR   = 10;
  localparam int MAXV  = (1 << ACC_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             strobe = 1'b0;
  logic [ACC_W-1:0] level;
  logic             over;
  int               cyc = 0;
  int               total_cyc = 0;
  int               n_cmp = 0;
  int               n_bad = 0;

  always #4 clk = ~clk;

  leaky_edge_counter #(.ACC_W(ACC_W), .LEAK_CYCLES(LEAK), .THRESHOLD(THR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .level_o(level), .over_o(over)
  );

  always @(posedge clk) begin
    total_cyc <= total_cyc + 1;
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input int exp);
    check(req, int'(level), exp);
    check({req, " R6 flag"}, int'(over), (exp > THR) ? 1 : 0);
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset level", int'(level), 0);
    check("R7 reset flag", int'(over), 0);
    rst_n = 1'b1;
  endtask

  task automatic pulses(input int n, input real half);
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1; #(half);
      strobe = 1'b0; #(half);
    end
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog: got %0d expected 0 cycles left", total_cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n <= 20; n++) begin
        do_reset();
        pulses(2, 9.0);                        // absorbed by strobe reset release, R8
        pulses(n, (pass == 0) ? 9.0 : 2.0);    // pass 1 is 2x clk rate, R2
        wait_until(60);
        check_out((pass == 0) ? "R1 R8 burst" : "R2 R8 fast burst", n);
        wait_until(80);
        check_out("R3 R4 first leak", (n > 0) ? n - 1 : 0);
        wait_until(120);
        check_out("R9 stopped strobe holds", (n > 0) ? n - 1 : 0);
        wait_until(LEAK * (n + 2) + 16);
        check_out("R4 drained floor", 0);
      end
    end
    // saturation with leak ticks landing mid-burst
    do_reset();
    pulses(2, 9.0);
    pulses(45, 9.0);
    wait_until(115);
    check_out("R5 ceiling", MAXV);
    wait_until(2 * LEAK + 10);
    check_out("R5 R3 leak from ceiling", MAXV - 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule